// File: doc/BRIEF.md
# Programmable Watchdog Timer

This block watches for signs of life from a processor. Software programs one byte-wide setup register. The register holds a 5-bit multiplier, a 2-bit resolution code and a steering bit. The timeout, counted in ticks of an external prescaled time base, is the multiplier times the selected resolution. Each tick stands for 1/16 s. Either edge of the asynchronous kick input restarts the countdown, and so does any write to the setup register.

When the countdown expires, the block raises the watchdog flag. The steering bit then decides what follows:

- **Interrupt mode:** a level interrupt is raised and held.
- **Reset mode:** a reset pulse of fixed length is sent out. A one-cycle strobe tells neighbouring blocks to clear their enable bits, and the setup register is cleared, which leaves the watchdog disabled.

A multiplier of zero disables the countdown. The flag is cleared by a read strobe of the flags register, in which the flag sits at bit 7.

Top module: `wdog_timer`

## Requirements
- R1: After reset, the setup readback is 0x00, and the flag, interrupt, reset pulse and peer-clear outputs are all low.
- R2: Setup bits 6:2 hold the multiplier M and bits 1:0 hold the resolution code. Code 00 gives 1 tick, 01 gives 4 ticks, 10 gives 16 ticks and 11 gives 64 ticks. Expiry happens on the edge that samples the (M x resolution)-th tick after a restart, and the flag is high from that edge on.
- R3: Any write to the setup register reloads the countdown from the written value.
- R4: The kick input passes through a two-flop synchronizer. Both its rising and its falling edges reload the countdown from the current setup value.
- R5: With a multiplier of zero, no expiry ever occurs, whatever the number of ticks.
- R6: With bit 7 at 0, expiry raises the interrupt. The interrupt stays high through writes of nonzero values and through flag reads. Only a write of 0x00 drops it.
- R7: With bit 7 at 1, expiry has three effects:
  - the reset output goes high for exactly RST_CYCLES clock cycles;
  - the peer-clear output pulses high for one cycle;
  - the setup register reads back 0x00, so no further expiry occurs.
- R8: A flag-read strobe clears the flag. If a flag read and an expiry happen in the same cycle, the flag ends up set.
- R9: The setup readback always shows the last value written, or 0x00 after a reset-mode expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset (power-down clear) |
| tick | input | 1 | One-cycle time-base pulse, one per 1/16 s |
| kickIn | input | 1 | Asynchronous kick; either edge restarts the countdown |
| cfgWe | input | 1 | Setup register write strobe |
| cfgWdata | input | 8 | Setup write data |
| cfgRdata | output | 8 | Setup register readback |
| flagRd | input | 1 | Flags-register read strobe; clears the watchdog flag |
| wdFlag | output | 1 | Watchdog flag (bit 7 of the flags register) |
| irqOut | output | 1 | Interrupt, active high, held until 0x00 is written |
| rstPulseOut | output | 1 | Fixed-length reset pulse, active high |
| peerClr | output | 1 | One-cycle strobe to clear the neighbours' enable bits |

## Verification
A table of setup codes walks every resolution code and several multipliers. The bench checks that no expiry happens one tick early and that expiry does happen on the final tick, so a design that miscounts, or that maps a resolution code to the wrong shift, fires off by one tick or by a large factor.

Restarts by a write, by a rising kick and by a falling kick are each placed one tick before expiry. A design that catches only one kind of edge, or that ignores writes, would time out there.

Directed cases cover the remaining corners:
- a zero multiplier, where a broken enable would expire;
- a nonzero write after an interrupt, which a careless design would take as a clear;
- a flag read that coincides with expiry, where the wrong priority loses the event;
- the length of the reset pulse and the clearing of the setup register in reset mode.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // Strobes from control to the countdown datapath
  typedef struct packed {
    logic reload;  // load the countdown from the next setup value
    logic step;    // one time-base tick
  } wdStrb_t;
endpackage

// File: rtl/wdog_kick_sync.sv
module wdog_kick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic kickIn,
  output logic kickEdge
);
  logic [STAGES-1:0] syncQ;
  logic lastQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      lastQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[STAGES-2:0], kickIn};
      lastQ <= syncQ[STAGES-1];
    end
  end

  assign kickEdge = syncQ[STAGES-1] ^ lastQ;

  // R4
  edge_follows_sync_chk: assert property (@(posedge clk) disable iff (!rstN)
    kickEdge |=> (lastQ != $past(lastQ)));
endmodule

// File: rtl/wdog_count.sv
module wdog_count import wdog_pkg::*; #(
  parameter int MULT_W = 5,
  parameter int RES_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  wdStrb_t           strb,
  input  logic [MULT_W-1:0] multIn,
  input  logic [RES_W-1:0]  resIn,
  output logic              expire
);
  localparam int MAX_SHIFT = 2 * ((1 << RES_W) - 1);
  localparam int CNT_W     = MULT_W + MAX_SHIFT;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] loadVal;

  // Each resolution step is four times the previous one
  assign loadVal = CNT_W'(multIn) << {resIn, 1'b0};
  assign expire  = strb.step && !strb.reload && (cnt == CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        cnt <= '0;
    else if (strb.reload)             cnt <= loadVal;
    else if (strb.step && cnt != '0)  cnt <= cnt - 1'b1;
  end

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.reload && cnt != '0) |=> (cnt == $past(cnt) || cnt == $past(cnt) - 1'b1));
  // R5
  idle_stays_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.reload && cnt == '0) |=> (cnt == '0 && !expire));
  // R2
  expire_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> (cnt == '0));
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl import wdog_pkg::*; #(
  parameter int CFG_W      = 8,
  parameter int RST_CYCLES = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             kickEdge,
  input  logic             cfgWe,
  input  logic [CFG_W-1:0] cfgWdata,
  input  logic             flagRd,
  input  logic             expire,
  output wdStrb_t          strb,
  output logic [CFG_W-1:0] cfgNext,
  output logic [CFG_W-1:0] cfgQ,
  output logic             flagQ,
  output logic             irqQ,
  output logic             rstPulse,
  output logic             peerClrQ
);
  localparam int PW = $clog2(RST_CYCLES + 1);
  localparam int STEER_BIT = CFG_W - 1;

  logic [PW-1:0] pulseCnt;
  logic steer;
  logic resetHit;

  assign steer       = cfgQ[STEER_BIT];
  assign resetHit    = expire && steer;
  assign cfgNext     = cfgWe ? cfgWdata : cfgQ;
  assign strb.reload = cfgWe || kickEdge;
  assign strb.step   = tick;
  assign rstPulse    = (pulseCnt != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ     <= '0;
      flagQ    <= 1'b0;
      irqQ     <= 1'b0;
      pulseCnt <= '0;
      peerClrQ <= 1'b0;
    end else begin
      if (cfgWe)         cfgQ <= cfgWdata;
      else if (resetHit) cfgQ <= '0;

      if (expire)      flagQ <= 1'b1;
      else if (flagRd) flagQ <= 1'b0;

      if (expire && !steer)                   irqQ <= 1'b1;
      else if (cfgWe && cfgWdata == '0)       irqQ <= 1'b0;

      if (resetHit)             pulseCnt <= PW'(RST_CYCLES);
      else if (pulseCnt != '0)  pulseCnt <= pulseCnt - 1'b1;

      peerClrQ <= resetHit;
    end
  end

  // R8
  flag_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> flagQ);
  // R6
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && cfgWdata == '0) |=> !irqQ);
  // R6
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqQ && !(cfgWe && cfgWdata == '0)) |=> irqQ);
  // R7
  reset_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    resetHit |=> (cfgQ == '0 && rstPulse && peerClrQ));
  // R7
  peer_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    peerClrQ |=> !peerClrQ);
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer import wdog_pkg::*; #(
  parameter int CFG_W      = 8,
  parameter int MULT_W     = 5,
  parameter int RES_W      = 2,
  parameter int RST_CYCLES = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             kickIn,
  input  logic             cfgWe,
  input  logic [CFG_W-1:0] cfgWdata,
  output logic [CFG_W-1:0] cfgRdata,
  input  logic             flagRd,
  output logic             wdFlag,
  output logic             irqOut,
  output logic             rstPulseOut,
  output logic             peerClr
);
  logic kickEdge;
  logic expire;
  wdStrb_t strb;
  logic [CFG_W-1:0] cfgNext;

  wdog_kick_sync #(.STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .kickIn(kickIn), .kickEdge(kickEdge)
  );

  wdog_ctrl #(.CFG_W(CFG_W), .RST_CYCLES(RST_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN), .tick(tick), .kickEdge(kickEdge),
    .cfgWe(cfgWe), .cfgWdata(cfgWdata), .flagRd(flagRd), .expire(expire),
    .strb(strb), .cfgNext(cfgNext), .cfgQ(cfgRdata), .flagQ(wdFlag),
    .irqQ(irqOut), .rstPulse(rstPulseOut), .peerClrQ(peerClr)
  );

  wdog_count #(.MULT_W(MULT_W), .RES_W(RES_W)) uCount (
    .clk(clk), .rstN(rstN), .strb(strb),
    .multIn(cfgNext[RES_W +: MULT_W]), .resIn(cfgNext[RES_W-1:0]),
    .expire(expire)
  );
endmodule

// File: tb/sim_wdog_timer.sv
module sim_wdog_timer;
  localparam int RSTC = 16;
  localparam int NV = 6;
  localparam logic [7:0] VCFG [NV] = '{8'h04, 8'h05, 8'h09, 8'h0E, 8'h0B, 8'h7C};
  localparam int         VTCK [NV] = '{1,     4,     8,     48,    128,   31};

  logic clk = 0, rstN = 0, tick = 0, kickIn = 0, cfgWe = 0, flagRd = 0;
  logic [7:0] cfgWdata = 0;
  logic [7:0] cfgRdata;
  logic wdFlag, irqOut, rstPulseOut, peerClr;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  wdog_timer #(.RST_CYCLES(RSTC)) u0 (
    .clk(clk), .rstN(rstN), .tick(tick), .kickIn(kickIn), .cfgWe(cfgWe),
    .cfgWdata(cfgWdata), .cfgRdata(cfgRdata), .flagRd(flagRd), .wdFlag(wdFlag),
    .irqOut(irqOut), .rstPulseOut(rstPulseOut), .peerClr(peerClr)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    cfgWe = 1; cfgWdata = d;
    @(negedge clk); cfgWe = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1; @(negedge clk); tick = 0; @(negedge clk);
    end
  endtask

  task automatic rdFlag();
    flagRd = 1; @(negedge clk); flagRd = 0;
  endtask

  task automatic clearAll();
    wr(8'h00); rdFlag();
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 cfg", cfgRdata, 0); chk("R1 flag", wdFlag, 0); chk("R1 irq", irqOut, 0);
    chk("R1 rst", rstPulseOut, 0); chk("R1 peer", peerClr, 0);
    rstN = 1; @(negedge clk);

    // R2 vector walk: no expiry one tick early, expiry on the last tick
    for (int v = 0; v < NV; v++) begin
      wr(VCFG[v]);
      chk("R9 readback", cfgRdata, VCFG[v]);
      ticks(VTCK[v] - 1);
      chk("R2 early flag", wdFlag, 0);
      ticks(1);
      chk("R2 flag", wdFlag, 1);
      chk("R6 irq", irqOut, 1);
      clearAll();
      chk("R8 flag clr", wdFlag, 0);
      chk("R6 irq clr", irqOut, 0);
    end

    // R3 write restarts
    wr(8'h05); ticks(3); wr(8'h05); ticks(3);
    chk("R3 no expiry", wdFlag, 0);
    ticks(1); chk("R3 expiry", wdFlag, 1);
    clearAll();

    // R4 rising and falling kick edges restart
    wr(8'h05); ticks(3); kickIn = 1; repeat (5) @(negedge clk); ticks(3);
    chk("R4 rise no expiry", wdFlag, 0);
    ticks(1); chk("R4 rise expiry", wdFlag, 1);
    clearAll();
    wr(8'h05); ticks(3); kickIn = 0; repeat (5) @(negedge clk); ticks(3);
    chk("R4 fall no expiry", wdFlag, 0);
    ticks(1); chk("R4 fall expiry", wdFlag, 1);
    clearAll();

    // R5 zero multiplier disables
    wr(8'h03); ticks(200);
    chk("R5 flag", wdFlag, 0); chk("R5 irq", irqOut, 0);

    // R6 nonzero write and flag read do not clear irq
    wr(8'h04); ticks(1);
    rdFlag(); chk("R6 irq after read", irqOut, 1); chk("R8 flag read", wdFlag, 0);
    wr(8'h05); chk("R6 irq after nonzero", irqOut, 1);
    wr(8'h00); chk("R6 irq zero write", irqOut, 0);

    // R8 set wins over simultaneous read
    wr(8'h04);
    tick = 1; flagRd = 1; @(negedge clk); tick = 0; flagRd = 0;
    chk("R8 set wins", wdFlag, 1);
    rdFlag(); chk("R8 clear", wdFlag, 0);
    clearAll();

    // R7 reset mode
    begin
      int hi = 0, pc = 0;
      wr(8'h84); chk("R9 readback steer", cfgRdata, 8'h84);
      tick = 1; @(negedge clk); tick = 0;
      chk("R7 cfg cleared", cfgRdata, 0);
      chk("R7 irq stays low", irqOut, 0);
      chk("R7 flag", wdFlag, 1);
      for (int i = 0; i < RSTC + 6; i++) begin
        if (rstPulseOut) hi++;
        if (peerClr) pc++;
        @(negedge clk);
      end
      chk("R7 pulse width", hi, RSTC);
      chk("R7 peer pulses", pc, 1);
      rdFlag(); ticks(10);
      chk("R7 disabled after", wdFlag, 0);
      chk("R7 no second pulse", rstPulseOut, 0);
    end

    summary();
  end
endmodule